// File: doc/BRIEF.md
# Composite Video Color Carrier Generator

This block produces the chroma subcarrier part of a composite video signal and merges it with a luma level into a 4-bit code for an external binary-weighted resistor DAC. A 24-bit phase accumulator advances by a programmable increment on every clock, so the increment sets the subcarrier frequency. The top bits of the accumulator, plus a hue offset, address a 16-entry table of true sine samples held as 4-bit two's complement values.

Saturation is set by a sign-preserving arithmetic right shift of the sine sample. Two colors are available, foreground and background, and each has its own hue offset. A select bit picks the color. A gate input switches the carrier on during burst or active video. When the gate is low, only the luma level reaches the output. Sync generation, line timing and the DAC are handled outside the block.

Top module: `ccar_gen`

## Requirements
- R1: While `rst_n` is low, `dac_code` is 0 and the phase accumulator is held at 0. The first clock edge after release therefore uses table index 0 plus the selected hue offset.
- R2: On each rising clock edge out of reset, the accumulator adds `phase_inc`, wrapping modulo 2^24.
- R3: The table index is accumulator bits [23:20] plus the selected 4-bit hue offset, taken modulo 16.
- R4: The sine table maps index 0..15 to 0, 3, 5, 6, 7, 6, 5, 3, 0, -3, -5, -6, -7, -6, -5, -3.
- R5: The carrier is the sample arithmetically shifted right by `sat_shift` (0..3). Every bit shifted in is a copy of the sign bit. A negative sample stays negative (at least down to -1), a non-negative sample never becomes negative, and a shift of 0 leaves the sample unchanged.
- R6: With the gate high, the code is `luma` plus the carrier as a signed sum, clamped to the range 0..15.
- R7: With `gate` low, the carrier adds nothing and the code equals `luma`.
- R8: When `color_sel` is 1, `hue_fg` is the offset used. When it is 0, `hue_bg` is used.
- R9: `dac_code` is registered. The value shown after a rising edge is computed from the accumulator value and the inputs present just before that edge. Input changes between edges do not show until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_inc | input | 24 | Accumulator step per clock (sets the subcarrier frequency) |
| sat_shift | input | 2 | Arithmetic right shift applied to the sine sample |
| luma | input | 4 | Unsigned luma level |
| hue_fg | input | 4 | Hue phase offset of the foreground color |
| hue_bg | input | 4 | Hue phase offset of the background color |
| color_sel | input | 1 | 1 selects foreground, 0 selects background |
| gate | input | 1 | 1 enables the carrier (burst or active video) |
| dac_code | output | 4 | Unsigned code for the resistor DAC |

## Verification
Each code is due exactly one rising edge after the accumulator value and the inputs it depends on. The bench keeps its own accumulator, which it advances at that same edge. It computes the expected code just before the edge and samples the output 2 ns after it. Inputs only change after that sample point, which leaves them stable across each edge. One check samples the output after a luma change but before the next edge, and confirms that the old value still holds there.

// File: rtl/ccar_pkg.sv
package ccar_pkg;
   localparam int ACC_W_DEF  = 24;
   localparam int IDX_W_DEF  = 4;
   localparam int SAMP_W_DEF = 4;
   localparam int CODE_W_DEF = 4;
   localparam int SH_W_DEF   = 2;

   typedef enum logic {
      SEL_BG = 1'b0,
      SEL_FG = 1'b1
   } csel_e;

   // Quarter-wave magnitudes for positions 0..3 of a 16-step period.
   function automatic logic [3:0] quarter_mag(input logic [1:0] pos);
      logic [3:0] m;
      case (pos)
         2'd0:    m = 4'd0;
         2'd1:    m = 4'd3;
         2'd2:    m = 4'd5;
         default: m = 4'd6;
      endcase
      return m;
   endfunction
endpackage

// File: rtl/ccar_nco.sv
module ccar_nco #(
   parameter int ACC_W = ccar_pkg::ACC_W_DEF,
   parameter int IDX_W = ccar_pkg::IDX_W_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ACC_W-1:0] inc,
   output logic [IDX_W-1:0] phase_o
);
   localparam int TOP = ACC_W - 1;

   generate
      if (IDX_W > ACC_W) begin : g_bad_idx
         $error("ccar_nco: IDX_W must not exceed ACC_W");
      end
   endgenerate

   logic [ACC_W-1:0] acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc <= '0;
      else        acc <= acc + inc;
   end

   assign phase_o = acc[TOP -: IDX_W];

   AST_NCO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> acc == ACC_W'($past(acc) + $past(inc))) else $error("nco step"); // R2
endmodule

// File: rtl/ccar_sine.sv
module ccar_sine #(
   parameter int IDX_W        = ccar_pkg::IDX_W_DEF,
   parameter int SAMP_W       = ccar_pkg::SAMP_W_DEF,
   parameter bit QUARTER_WAVE = 1'b1
) (
   input  logic [IDX_W-1:0]         idx,
   output logic signed [SAMP_W-1:0] samp
);
   localparam int PEAK = 7;

   generate
      if (IDX_W != 4 || SAMP_W != 4) begin : g_bad_size
         $error("ccar_sine: table is defined for 16 entries of 4 bits");
      end
   endgenerate

   generate
      if (QUARTER_WAVE) begin : g_quarter
         logic [1:0] pos;
         logic [3:0] mag;
         assign pos = idx[1:0];
         always_comb begin
            if (!idx[2])       mag = ccar_pkg::quarter_mag(pos);
            else if (pos == 0) mag = 4'(PEAK);
            else               mag = ccar_pkg::quarter_mag(2'(-pos));
         end
         assign samp = idx[3] ? -$signed(mag) : $signed(mag);
      end else begin : g_flat
         always_comb begin
            case (idx)
               4'd0:  samp = 4'sd0;
               4'd1:  samp = 4'sd3;
               4'd2:  samp = 4'sd5;
               4'd3:  samp = 4'sd6;
               4'd4:  samp = 4'sd7;
               4'd5:  samp = 4'sd6;
               4'd6:  samp = 4'sd5;
               4'd7:  samp = 4'sd3;
               4'd8:  samp = 4'sd0;
               4'd9:  samp = -4'sd3;
               4'd10: samp = -4'sd5;
               4'd11: samp = -4'sd6;
               4'd12: samp = -4'sd7;
               4'd13: samp = -4'sd6;
               4'd14: samp = -4'sd5;
               default: samp = -4'sd3;
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/ccar_scale.sv
module ccar_scale #(
   parameter int SAMP_W = ccar_pkg::SAMP_W_DEF,
   parameter int SH_W   = ccar_pkg::SH_W_DEF
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic signed [SAMP_W-1:0] samp,
   input  logic [SH_W-1:0]          shift,
   output logic signed [SAMP_W-1:0] car
);
   localparam int MSB = SAMP_W - 1;

   generate
      if ((1 << SH_W) > SAMP_W) begin : g_bad_shift
         $error("ccar_scale: shift range exceeds sample width");
      end
   endgenerate

   assign car = samp >>> shift;

   AST_SIGN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      samp[MSB] |-> car[MSB]) else $error("negative sample lost sign"); // R5
   AST_SIGN_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
      !samp[MSB] |-> !car[MSB]) else $error("positive sample turned negative"); // R5
   AST_UNITY: assert property (@(posedge clk) disable iff (!rst_n)
      shift == '0 |-> car == samp) else $error("zero shift altered sample"); // R5
endmodule

// File: rtl/ccar_mix.sv
module ccar_mix #(
   parameter int SAMP_W = ccar_pkg::SAMP_W_DEF,
   parameter int CODE_W = ccar_pkg::CODE_W_DEF
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [CODE_W-1:0]        luma,
   input  logic signed [SAMP_W-1:0] car,
   input  logic                     gate,
   output logic [CODE_W-1:0]        code
);
   localparam int SUM_W = CODE_W + 2;
   localparam int MAXV  = (1 << CODE_W) - 1;
   localparam int MSB   = SAMP_W - 1;

   generate
      if (SAMP_W > CODE_W + 1) begin : g_bad_width
         $error("ccar_mix: carrier wider than sum allows");
      end
   endgenerate

   logic signed [SUM_W-1:0] luma_s, car_s, sum;
   logic [CODE_W-1:0]       clamped;

   assign luma_s = $signed({2'b00, luma});
   assign car_s  = gate ? $signed({{(SUM_W-SAMP_W){car[MSB]}}, car}) : '0;
   assign sum    = luma_s + car_s;

   always_comb begin
      if (sum < 0)                         clamped = '0;
      else if (sum > SUM_W'(MAXV))         clamped = CODE_W'(MAXV);
      else                                 clamped = sum[CODE_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code <= '0;
      else        code <= clamped;
   end

   AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !gate |=> code == $past(luma)) else $error("gate off leaked carrier"); // R7
   AST_CLAMP_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (gate && !car[MSB] && luma == CODE_W'(MAXV)) |=> code == CODE_W'(MAXV)) else $error("top clamp"); // R6
   AST_CLAMP_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (gate && car[MSB] && luma == '0) |=> code == '0) else $error("bottom clamp"); // R6
endmodule

// File: rtl/ccar_gen.sv
module ccar_gen #(
   parameter int ACC_W        = ccar_pkg::ACC_W_DEF,
   parameter int IDX_W        = ccar_pkg::IDX_W_DEF,
   parameter int SAMP_W       = ccar_pkg::SAMP_W_DEF,
   parameter int CODE_W       = ccar_pkg::CODE_W_DEF,
   parameter int SH_W         = ccar_pkg::SH_W_DEF,
   parameter bit QUARTER_WAVE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ACC_W-1:0]  phase_inc,
   input  logic [SH_W-1:0]   sat_shift,
   input  logic [CODE_W-1:0] luma,
   input  logic [IDX_W-1:0]  hue_fg,
   input  logic [IDX_W-1:0]  hue_bg,
   input  logic              color_sel,
   input  logic              gate,
   output logic [CODE_W-1:0] dac_code
);
   import ccar_pkg::*;

   logic [IDX_W-1:0]         phase, hue, idx;
   logic signed [SAMP_W-1:0] samp, car;
   csel_e                    sel;

   assign sel = csel_e'(color_sel);
   assign hue = (sel == SEL_FG) ? hue_fg : hue_bg;
   assign idx = phase + hue;

   ccar_nco #(.ACC_W(ACC_W), .IDX_W(IDX_W)) u_nco (
      .clk(clk), .rst_n(rst_n), .inc(phase_inc), .phase_o(phase));

   ccar_sine #(.IDX_W(IDX_W), .SAMP_W(SAMP_W), .QUARTER_WAVE(QUARTER_WAVE)) u_sine (
      .idx(idx), .samp(samp));

   ccar_scale #(.SAMP_W(SAMP_W), .SH_W(SH_W)) u_scale (
      .clk(clk), .rst_n(rst_n), .samp(samp), .shift(sat_shift), .car(car));

   ccar_mix #(.SAMP_W(SAMP_W), .CODE_W(CODE_W)) u_mix (
      .clk(clk), .rst_n(rst_n), .luma(luma), .car(car), .gate(gate), .code(dac_code));

   AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |-> dac_code == '0)
      else $error("code not cleared in reset"); // R1
endmodule

// File: tb/sim_ccar_gen.sv
module sim_ccar_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] phase_inc = '0;
   logic [1:0]  sat_shift = '0;
   logic [3:0]  luma = '0;
   logic [3:0]  hue_fg = '0;
   logic [3:0]  hue_bg = '0;
   logic        color_sel = 1'b0;
   logic        gate = 1'b0;
   logic [3:0]  dac_code;

   int total = 0;
   int bad = 0;
   bit done = 0;
   logic [23:0] macc = '0;
   int sin_ref[16] = '{0, 3, 5, 6, 7, 6, 5, 3, 0, -3, -5, -6, -7, -6, -5, -3};

   always #10 clk = ~clk;

   ccar_gen u0 (
      .clk(clk), .rst_n(rst_n), .phase_inc(phase_inc), .sat_shift(sat_shift),
      .luma(luma), .hue_fg(hue_fg), .hue_bg(hue_bg), .color_sel(color_sel),
      .gate(gate), .dac_code(dac_code));

   task automatic check(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int model();
      logic [3:0] idx;
      int s, c, sum;
      idx = 4'(macc[23:20] + (color_sel ? hue_fg : hue_bg));
      s = sin_ref[idx];
      c = s >>> sat_shift;
      sum = int'(luma) + (gate ? c : 0);
      if (sum < 0) sum = 0;
      if (sum > 15) sum = 15;
      return sum;
   endfunction

   task automatic tick(string tag);
      int e;
      e = model();
      macc = macc + phase_inc;
      @(posedge clk);
      #2;
      check(tag, int'(dac_code), e);
   endtask

   task automatic do_reset();
      @(posedge clk); #5;
      rst_n = 1'b0;
      #1;
      check("R1 code zero in reset", int'(dac_code), 0);
      @(posedge clk); #5;
      rst_n = 1'b1;
      macc = '0;
      @(negedge clk); #2;
   endtask

   task automatic t_reset();
      phase_inc = 24'h0; luma = 4'd8; gate = 1'b1; color_sel = 1'b1; hue_fg = 4'd0;
      sat_shift = 2'd0;
      do_reset();
      tick("R1 first code uses phase zero");
   endtask

   task automatic t_sweep();
      phase_inc = 24'h100000; luma = 4'd8; gate = 1'b1; sat_shift = 2'd0;
      for (int i = 0; i < 16; i++) tick("R4 table sweep");
   endtask

   task automatic t_fine();
      phase_inc = 24'h0C0000; sat_shift = 2'd0; luma = 4'd8;
      for (int i = 0; i < 40; i++) tick("R2 fractional step");
      phase_inc = 24'hF00000;
      for (int i = 0; i < 20; i++) tick("R2 wrap backwards");
      phase_inc = 24'h123457;
      for (int i = 0; i < 60; i++) tick("R2 odd step");
   endtask

   task automatic t_hue();
      phase_inc = 24'h100000; luma = 4'd8; gate = 1'b1;
      hue_fg = 4'd8; hue_bg = 4'd4;
      color_sel = 1'b0;
      for (int i = 0; i < 8; i++) tick("R8 background hue");
      color_sel = 1'b1;
      for (int i = 0; i < 8; i++) tick("R8 foreground hue");
      hue_fg = 4'd15;
      for (int i = 0; i < 8; i++) tick("R3 index wraps mod 16");
      hue_fg = 4'd0;
   endtask

   task automatic t_shift();
      phase_inc = 24'h100000; luma = 4'd8; gate = 1'b1;
      for (int s = 1; s < 4; s++) begin
         sat_shift = 2'(s);
         for (int i = 0; i < 16; i++) tick("R5 arithmetic shift");
      end
      // luma 0 with shift 3: negatives give -1 then clamp to 0; luma 1 gives 0 not 2
      luma = 4'd1; sat_shift = 2'd3;
      for (int i = 0; i < 16; i++) tick("R5 sign kept at max shift");
      sat_shift = 2'd0;
   endtask

   task automatic t_clamp();
      phase_inc = 24'h100000; gate = 1'b1; sat_shift = 2'd0;
      luma = 4'd12;
      for (int i = 0; i < 16; i++) tick("R6 clamp high");
      luma = 4'd2;
      for (int i = 0; i < 16; i++) tick("R6 clamp low");
      luma = 4'd15;
      for (int i = 0; i < 16; i++) tick("R6 full luma");
   endtask

   task automatic t_gate();
      phase_inc = 24'h100000; gate = 1'b0; sat_shift = 2'd0;
      for (int i = 0; i < 16; i++) begin
         luma = 4'(i);
         tick("R7 gate low gives luma");
      end
      luma = 4'd3;
      tick("R9 settle");
      luma = 4'd11;
      #3;
      check("R9 no change before edge", int'(dac_code), 3);
      tick("R9 change after edge");
   endtask

   task automatic t_rereset();
      phase_inc = 24'h0A0000; gate = 1'b1; luma = 4'd8; color_sel = 1'b0; hue_bg = 4'd2;
      for (int i = 0; i < 5; i++) tick("R2 before reset");
      phase_inc = 24'h0;
      do_reset();
      tick("R1 accumulator cleared");
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_sweep();
      t_fine();
      t_hue();
      t_shift();
      t_clamp();
      t_gate();
      t_rereset();
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule